// File: doc/BRIEF.md
# PWM Time-Base Counter with Cascaded Prescaler

This block is the timing reference for a two-channel pulse-width modulator. Two prescaler stages in series turn the system clock into a tick enable. A binary stage divides by a power of two, and a second stage divides by an even step. A counter advances once per tick. It can count up, count down or count up-down, or it can be held frozen. The compare and action logic of the channels reads the counter value and the two event pulses. One pulse marks the counter at zero and the other marks the counter at the programmed period value.

Software sets the block up through a plain write-only register port. Address 0 is the control word, which carries the mode, the two prescaler codes and a free-run field. Address 1 is the period register, which takes effect on the next tick with no shadowing. The register port has no back-pressure: every write strobe is accepted on the clock edge where it is sampled. Control and status pins are plain levels and pulses, so the block has no valid/ready handshake.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter reads 0, the mode is freeze with no events, and both prescaler codes are 0, so the tick output is high on every clock.
- R2: A write with `wr_addr_i`=0 loads the control word and a write with `wr_addr_i`=1 loads the period value P. Both take effect at the clock edge that samples the strobe.
- R3: Control bits 12:10 hold code n, and the first prescaler stage divides by 2^n (1 to 128).
- R4: Control bits 9:7 hold code m, and the second stage divides by 2*m, with code 0 meaning divide by 1. The tick period in clocks is the product of the two divisors.
- R5: Control bits 1:0 select the mode: 0 up, 1 down, 2 up-down, 3 freeze. In up mode the counter steps 0,1,…,P and then returns to 0, giving a cycle of P+1 ticks.
- R6: In down mode the counter steps P,…,1,0 and then reloads P, giving a cycle of P+1 ticks.
- R7: In up-down mode the counter rises to P and falls to 0 without repeating either end value, giving a cycle of 2P ticks. With P=0 it stays at 0.
- R8: In freeze mode the counter holds its value and no event pulses are produced.
- R9: `zero_o` is high for exactly one clock, on a tick where the counter is 0. `period_o` behaves the same way for a counter value of P. With P=0 both fire together.
- R10: The counter changes only in clocks where `tick_o` is high.
- R11: If P is written below the current count, up mode returns to 0 on the next tick and down mode reloads P on the next tick.
- R12: `free_run_o` is high only while control bits 15:14 hold the value 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register select: 0 control, 1 period |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| tick_o | output | 1 | Prescaled tick enable |
| zero_o | output | 1 | Pulse on a tick with the counter at 0 |
| period_o | output | 1 | Pulse on a tick with the counter at P |
| free_run_o | output | 1 | Free-run field decoded |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and 3-bit codes for both prescaler stages. These defaults make every divisor reachable, including the largest combination of 128 times 14, which gives a tick every 1792 clocks.

Small period values keep each measured cycle short. This lets the bench time the gaps from zero event to period event and from one zero event to the next in all three counting modes, for many prescaler pairs. It can also trace the up-down turning points value by value.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_UPDOWN = 2'd2,
    CNT_FREEZE = 2'd3
  } cnt_mode_e;

  // control word field positions
  localparam int MODE_LSB  = 0;
  localparam int STEP_LSB  = 7;
  localparam int BIN_LSB   = 10;
  localparam int FREE_LSB  = 14;
  localparam logic [1:0] FREE_RUN_CODE = 2'd2;

  localparam int ADDR_CTL = 0;
  localparam int ADDR_PRD = 1;
endpackage

// File: rtl/pwm_timebase_regs.sv
module pwm_timebase_regs
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 1,
  parameter int CLKDIV_W = 3,
  parameter int HSDIV_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  output cnt_mode_e           mode_o,
  output logic [CLKDIV_W-1:0] bin_code_o,
  output logic [HSDIV_W-1:0]  step_code_o,
  output logic                free_run_o,
  output logic [CNT_W-1:0]    prd_o
);
  logic ctl_sel, prd_sel;
  assign ctl_sel = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTL));
  assign prd_sel = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_PRD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= CNT_FREEZE;
      bin_code_o  <= '0;
      step_code_o <= '0;
      free_run_o  <= 1'b0;
    end else if (ctl_sel) begin
      mode_o      <= cnt_mode_e'(wr_data_i[MODE_LSB +: 2]);
      bin_code_o  <= wr_data_i[BIN_LSB +: CLKDIV_W];
      step_code_o <= wr_data_i[STEP_LSB +: HSDIV_W];
      free_run_o  <= (wr_data_i[FREE_LSB +: 2] == FREE_RUN_CODE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prd_o <= '0;
    else if (prd_sel) prd_o <= wr_data_i;
  end
endmodule

// File: rtl/pwm_timebase_presc.sv
module pwm_timebase_presc #(
  parameter int CLKDIV_W = 3,
  parameter int HSDIV_W  = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CLKDIV_W-1:0] bin_code_i,
  input  logic [HSDIV_W-1:0]  step_code_i,
  output logic                tick_o
);
  localparam int S1_W = (1 << CLKDIV_W) - 1;
  localparam int S2_W = HSDIV_W + 1;

  logic [S1_W-1:0] s1_cnt, s1_lim;
  logic [S2_W-1:0] s2_cnt, s2_lim;
  logic            s1_last, s2_last;

  // binary stage: limit 2^n - 1 (wraps to all ones for the top code)
  assign s1_lim  = (S1_W'(1) << bin_code_i) - S1_W'(1);
  assign s1_last = (s1_cnt >= s1_lim);

  // even-step stage: limit 2m - 1, or 0 for code 0
  assign s2_lim  = (step_code_i == '0) ? '0 : ({step_code_i, 1'b0} - S2_W'(1));
  assign s2_last = (s2_cnt >= s2_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_cnt <= '0;
      s2_cnt <= '0;
      tick_o <= 1'b0;
    end else begin
      s1_cnt <= s1_last ? '0 : s1_cnt + S1_W'(1);
      if (s1_last) s2_cnt <= s2_last ? '0 : s2_cnt + S2_W'(1);
      tick_o <= s1_last && s2_last;
    end
  end
endmodule

// File: rtl/pwm_timebase_cnt.sv
module pwm_timebase_cnt
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             period_o
);
  logic rising;
  logic live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      rising  <= 1'b1;
    end else if (tick_i) begin
      unique case (mode_i)
        CNT_UP: count_o <= (count_o >= prd_i) ? '0 : count_o + CNT_W'(1);
        CNT_DOWN: count_o <= (count_o == '0 || count_o > prd_i) ? prd_i
                                                                 : count_o - CNT_W'(1);
        CNT_UPDOWN: begin
          if (prd_i == '0) begin
            count_o <= '0;
            rising  <= 1'b1;
          end else if (rising) begin
            if (count_o >= prd_i) begin
              count_o <= count_o - CNT_W'(1);
              rising  <= 1'b0;
            end else begin
              count_o <= count_o + CNT_W'(1);
            end
          end else if (count_o == '0) begin
            count_o <= CNT_W'(1);
            rising  <= 1'b1;
          end else begin
            count_o <= count_o - CNT_W'(1);
          end
        end
        default: count_o <= count_o;
      endcase
    end
  end

  assign live     = tick_i && (mode_i != CNT_FREEZE);
  assign zero_o   = live && (count_o == '0);
  assign period_o = live && (count_o == prd_i);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 1,
  parameter int CLKDIV_W = 3,
  parameter int HSDIV_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              tick_o,
  output logic              zero_o,
  output logic              period_o,
  output logic              free_run_o
);
  cnt_mode_e           ctl_mode;
  logic [CLKDIV_W-1:0] bin_code;
  logic [HSDIV_W-1:0]  step_code;
  logic [CNT_W-1:0]    prd_q;

  pwm_timebase_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CLKDIV_W(CLKDIV_W), .HSDIV_W(HSDIV_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .mode_o(ctl_mode), .bin_code_o(bin_code),
    .step_code_o(step_code), .free_run_o(free_run_o), .prd_o(prd_q)
  );

  pwm_timebase_presc #(
    .CLKDIV_W(CLKDIV_W), .HSDIV_W(HSDIV_W)
  ) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .bin_code_i(bin_code),
    .step_code_i(step_code), .tick_o(tick_o)
  );

  pwm_timebase_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_o), .mode_i(ctl_mode),
    .prd_i(prd_q), .count_o(count_o), .zero_o(zero_o), .period_o(period_o)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] prd_i,
  input logic [CNT_W-1:0] count_i,
  input logic             zero_i,
  input logic             period_i
);
  // R10
  stable_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_i));

  // R9
  event_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_i || period_i) |-> (tick_i && mode_i != 2'd3));

  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> $stable(count_i));

  // R5
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 2'd0 && count_i < prd_i) |=> (count_i == $past(count_i) + CNT_W'(1)));

  // R5
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 2'd0 && count_i == prd_i) |=> (count_i == '0));

  // R6
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 2'd1 && count_i != '0 && count_i <= prd_i)
      |=> (count_i == $past(count_i) - CNT_W'(1)));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_o), .mode_i(ctl_mode),
  .prd_i(prd_q), .count_i(count_o), .zero_i(zero_o), .period_i(period_o)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        tick, zero, period, free_run;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pwm_timebase u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .count_o(count), .tick_o(tick), .zero_o(zero),
    .period_o(period), .free_run_o(free_run)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act %0d exp below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // mode, n, m, P, zero-to-period gap, zero-to-zero gap (clocks)
  localparam int VEC [9][6] = '{
    '{0, 0, 0, 4,    4,    5},
    '{0, 1, 0, 3,    6,    8},
    '{0, 0, 2, 2,    8,   12},
    '{1, 2, 0, 4,    4,   20},
    '{2, 0, 0, 3,    3,    6},
    '{2, 1, 1, 2,    8,   16},
    '{0, 3, 3, 1,   48,   96},
    '{1, 0, 0, 0,    0,    1},
    '{2, 7, 7, 1, 1792, 3584}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctlw(input int mode, input int n, input int m);
    return (n << 10) | (m << 7) | mode;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int seq [8];
    int p_gap, z_gap, t, n_zero, n_chg, last, guard;
    bit found;

    // R1 reset state
    do_reset();
    for (int i = 0; i < 10; i++) begin
      chk("R1 count", count, 0);
      chk("R1 events", int'(zero) + int'(period), 0);
      chk("R1 tick", tick, 1);
      @(negedge clk);
    end

    // R11 up mode: period lowered below count
    wr(1, 200);
    wr(0, ctlw(0, 0, 0));
    repeat (60) @(negedge clk);
    wr(1, 10);
    @(negedge clk);
    chk("R11 up wraps to 0", count, 0);

    // R11 down mode: reload lowered period
    wr(1, 200);
    wr(0, ctlw(1, 0, 0));
    repeat (30) @(negedge clk);
    wr(1, 10);
    @(negedge clk);
    chk("R11 down reloads P", count, 10);

    // R7 up-down trace with no repeated end values
    do_reset();
    wr(1, 3);
    wr(0, ctlw(2, 0, 0));
    chk("R7 start", count, 0);
    chk("R9 zero at start", zero, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seq[i] = count;
    end
    chk("R7 s0", seq[0], 1); chk("R7 s1", seq[1], 2);
    chk("R7 s2", seq[2], 3); chk("R7 s3", seq[3], 2);
    chk("R7 s4", seq[4], 1); chk("R7 s5", seq[5], 0);
    chk("R7 s6", seq[6], 1); chk("R7 s7", seq[7], 2);

    // R8 freeze holds and suppresses events
    wr(0, ctlw(3, 0, 0));
    last = count;
    n_zero = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (count != last) n_zero++;
      if (zero || period) n_zero++;
    end
    chk("R8 frozen", n_zero, 0);

    // R9 single-clock pulses and R10 movement only on ticks (tick every 4 clocks)
    wr(1, 2);
    wr(0, ctlw(0, 2, 0));
    repeat (20) @(negedge clk);
    n_zero = 0; n_chg = 0; last = count;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (zero) n_zero++;
      if (count != last) n_chg++;
      last = count;
    end
    chk("R9 zero pulses in 120 clocks", n_zero, 10);
    chk("R10 counter steps in 120 clocks", n_chg, 30);

    // R3 R4 R5 R6 R7 R9 R2 vector table
    for (int v = 0; v < 9; v++) begin
      wr(1, VEC[v][3]);
      wr(0, ctlw(VEC[v][0], VEC[v][1], VEC[v][2]));
      guard = 0;
      while (!zero && guard < 10000) begin
        @(negedge clk);
        guard++;
      end
      found = period;
      p_gap = found ? 0 : -1;
      t = 0;
      do begin
        @(negedge clk);
        t++;
        if (!found && period) begin
          found = 1'b1;
          p_gap = t;
        end
      end while (!zero && t < 10000);
      z_gap = t;
      chk($sformatf("R9 R3 R4 vec%0d zero-to-period", v), p_gap, VEC[v][4]);
      chk($sformatf("R5 R6 R7 vec%0d zero-to-zero", v), z_gap, VEC[v][5]);
    end

    // R12 free-run field decode
    wr(0, 16'h8000);
    chk("R12 code 2", free_run, 1);
    wr(0, 16'h4000);
    chk("R12 code 1", free_run, 0);
    wr(0, 16'hC000);
    chk("R12 code 3", free_run, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule